// File: doc/BRIEF.md
# PCI Transaction Data Phase Tracker

This block watches the three handshake strobes of a conventional PCI bus from the seat of a bus agent. The strobes are FRAME#, IRDY# and TRDY#, all active low and idle high. It does not drive the bus. It follows each transaction from the address phase through its data phases and back to idle. On every clock where a data phase completes, it captures the AD word and pulses a one-cycle valid strobe. It also flags the final phase of a transaction, counts completed phases and counts wait cycles.

The command direction is sampled once, in the address phase, and held on an output for the whole transaction. Phase completion and transaction end do not come from one valid/ready pair. They come from the two ready strobes together with the state of FRAME#. The master releases FRAME# before the final data phase, so a completion sampled with FRAME# high is the last one. A data phase in which both FRAME# and IRDY# are released without completing is reported as a protocol error, and the tracker drops back to idle.

All outputs are registered. Each result appears in the cycle after the clock edge that sampled the causing bus state.

Top module: `pci_phase_tracker`

## Requirements
- R1: While rst_ni is low, and after its release until the first bus event, dval_o, last_o, err_o and wr_o are 0, and data_o, phase_cnt_o and wait_cnt_o are all zero.
- R2: In idle, an edge that samples frame_ni low is the address phase. After that edge, phase_cnt_o and wait_cnt_o are 0 and wr_o equals is_write_i as sampled at that edge (1 = write, 0 = read).
- R3: In a data phase, an edge that samples both irdy_ni and trdy_ni low completes the phase. dval_o is then 1 for the following cycle and data_o equals ad_i sampled at that edge. data_o holds until the next completion.
- R4: phase_cnt_o increments by one on each completion and wraps modulo 2^PH_W.
- R5: In a data phase, an edge that samples irdy_ni or trdy_ni high, and is not a protocol error, increments wait_cnt_o by one.
- R6: wait_cnt_o saturates at 2^WAIT_W-1 (15 by default) instead of wrapping.
- R7: A completion sampled with frame_ni high sets last_o together with dval_o for one cycle, and returns the tracker to idle.
- R8: In a data phase, an edge that samples frame_ni and irdy_ni both high, without a completion, sets err_o for one cycle, produces no dval_o, and returns the tracker to idle.
- R9: While frame_ni stays low, successive completions continue the same burst without last_o. A new address phase may follow on the cycle right after a last phase, and it clears both counters.
- R10: In idle, low irdy_ni or trdy_ni produce no dval_o and leave data_o and both counters unchanged.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | FRAME#, active low |
| irdy_ni | input | 1 | IRDY#, active low |
| trdy_ni | input | 1 | TRDY#, active low |
| ad_i | input | DATA_W | AD bus |
| is_write_i | input | 1 | Command direction, 1 = write, sampled in the address phase |
| dval_o | output | 1 | One-cycle strobe: a data phase completed |
| data_o | output | DATA_W | Word captured at the last completion |
| last_o | output | 1 | Completed phase was the final one |
| err_o | output | 1 | One-cycle protocol error strobe |
| wr_o | output | 1 | Direction latched in the address phase |
| phase_cnt_o | output | PH_W | Completed data phases in this transaction |
| wait_cnt_o | output | WAIT_W | Wait cycles in this transaction, saturating |

## Verification
Every output is a single register stage away from the bus. The effect of a bus state sampled at one rising edge is therefore due exactly one cycle later, and only in that cycle for the strobes. The bench changes the bus strobes on the falling edge and waits for the next rising edge. It then reads the outputs 1 ns later, so each check observes the result of exactly one sampled bus state. Because the strobes are checked one cycle at a time, a strobe that lingers or comes a cycle late is caught as a mismatch on the neighbouring cycle.

// File: rtl/pci_trk_pkg.sv
package pci_trk_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } trk_state_e;
endpackage

// File: rtl/pci_trk_cnt.sv
module pci_trk_cnt #(
  parameter int W   = 8,
  parameter bit SAT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] nxt;

  generate
    if (SAT) begin : g_sat
      always_comb nxt = (q_o == MAX) ? q_o : q_o + 1'b1;
    end else begin : g_wrap
      always_comb nxt = q_o + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= nxt;
  end
endmodule

// File: rtl/pci_trk_fsm.sv
module pci_trk_fsm
  import pci_trk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic trdy_ni,
  output logic start_o,
  output logic done_o,
  output logic final_o,
  output logic err_o,
  output logic wait_o
);
  trk_state_e state_q, state_d;
  logic in_data, both_rdy;

  assign in_data  = (state_q == ST_DATA);
  assign both_rdy = !irdy_ni && !trdy_ni;

  assign start_o = (state_q == ST_IDLE) && !frame_ni;
  assign done_o  = in_data && both_rdy;
  assign final_o = done_o && frame_ni;
  // master gone without finishing: neither framing nor ready
  assign err_o   = in_data && !both_rdy && frame_ni && irdy_ni;
  assign wait_o  = in_data && !both_rdy && !err_o;

  always_comb begin
    state_d = state_q;
    if (start_o)             state_d = ST_DATA;
    else if (final_o || err_o) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/pci_phase_tracker.sv
module pci_phase_tracker #(
  parameter int DATA_W = 32,
  parameter int PH_W   = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  input  logic              trdy_ni,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              is_write_i,
  output logic              dval_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              err_o,
  output logic              wr_o,
  output logic [PH_W-1:0]   phase_cnt_o,
  output logic [WAIT_W-1:0] wait_cnt_o
);
  logic start, done, fin, err, wt;

  pci_trk_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_ni (frame_ni),
    .irdy_ni  (irdy_ni),
    .trdy_ni  (trdy_ni),
    .start_o  (start),
    .done_o   (done),
    .final_o  (fin),
    .err_o    (err),
    .wait_o   (wt)
  );

  pci_trk_cnt #(.W(PH_W), .SAT(1'b0)) u_phase_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .inc_i  (done),
    .q_o    (phase_cnt_o)
  );

  pci_trk_cnt #(.W(WAIT_W), .SAT(1'b1)) u_wait_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .inc_i  (wt),
    .q_o    (wait_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dval_o <= 1'b0;
      last_o <= 1'b0;
      err_o  <= 1'b0;
      wr_o   <= 1'b0;
      data_o <= '0;
    end else begin
      dval_o <= done;
      last_o <= fin;
      err_o  <= err;
      if (start) wr_o   <= is_write_i;
      // both readies low: AD valid for either direction
      if (done)  data_o <= ad_i;
    end
  end
endmodule

// File: rtl/pci_trk_chk.sv
module pci_trk_chk #(
  parameter int DATA_W = 32,
  parameter int PH_W   = 8,
  parameter int WAIT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_ni,
  input logic              irdy_ni,
  input logic              trdy_ni,
  input logic [DATA_W-1:0] ad_i,
  input logic              dval_o,
  input logic [DATA_W-1:0] data_o,
  input logic              last_o,
  input logic              err_o,
  input logic [PH_W-1:0]   phase_cnt_o,
  input logic [WAIT_W-1:0] wait_cnt_o
);
  localparam logic [WAIT_W-1:0] WMAX = {WAIT_W{1'b1}};

  AST_DVAL_NEEDS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dval_o |-> $past(!irdy_ni && !trdy_ni)); // R3
  AST_DATA_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dval_o |-> (data_o == $past(ad_i))); // R3
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dval_o |-> (phase_cnt_o == PH_W'($past(phase_cnt_o) + 1'b1))); // R4
  AST_WAIT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_cnt_o == WMAX) |=> (wait_cnt_o == WMAX || wait_cnt_o == '0)); // R6
  AST_LAST_WITH_DVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (dval_o && $past(frame_ni))); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!dval_o && $past(frame_ni && irdy_ni))); // R8
endmodule

bind pci_phase_tracker pci_trk_chk #(
  .DATA_W (DATA_W),
  .PH_W   (PH_W),
  .WAIT_W (WAIT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_ni    (frame_ni),
  .irdy_ni     (irdy_ni),
  .trdy_ni     (trdy_ni),
  .ad_i        (ad_i),
  .dval_o      (dval_o),
  .data_o      (data_o),
  .last_o      (last_o),
  .err_o       (err_o),
  .phase_cnt_o (phase_cnt_o),
  .wait_cnt_o  (wait_cnt_o)
);

// File: tb/tb_pci_phase_tracker.sv
module tb_pci_phase_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic        is_wr = 1'b0;
  logic        dval, last, err, wr;
  logic [31:0] data;
  logic [7:0]  pcnt;
  logic [3:0]  wcnt;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pci_phase_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .trdy_ni(trdy_n), .ad_i(ad), .is_write_i(is_wr), .dval_o(dval),
    .data_o(data), .last_o(last), .err_o(err), .wr_o(wr),
    .phase_cnt_o(pcnt), .wait_cnt_o(wcnt)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one bus clock, then sample just after the edge that saw it
  task automatic cyc(logic f, logic i, logic t, logic [31:0] d);
    @(negedge clk);
    frame_n = f; irdy_n = i; trdy_n = t; ad = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1", "dval", dval, 0);   chk("R1", "last", last, 0);
    chk("R1", "err", err, 0);     chk("R1", "wr", wr, 0);
    chk("R1", "data", data, 0);   chk("R1", "pcnt", pcnt, 0);
    chk("R1", "wcnt", wcnt, 0);
  endtask

  task automatic t_write_burst();
    is_wr = 1'b1;
    cyc(0, 1, 1, 32'hA000_0000);
    chk("R2", "wr", wr, 1); chk("R2", "pcnt", pcnt, 0); chk("R2", "dval", dval, 0);
    cyc(0, 0, 1, 32'h1111_1111);
    chk("R5", "wcnt", wcnt, 1); chk("R5", "dval", dval, 0);
    cyc(0, 0, 0, 32'h1111_1111);
    chk("R3", "dval", dval, 1); chk("R3", "data", data, 32'h1111_1111);
    chk("R4", "pcnt", pcnt, 1); chk("R9", "last", last, 0);
    cyc(1, 0, 0, 32'h2222_2222);
    chk("R7", "dval", dval, 1); chk("R7", "last", last, 1);
    chk("R3", "data", data, 32'h2222_2222); chk("R4", "pcnt", pcnt, 2);
    cyc(1, 1, 1, 32'h0);
    chk("R3", "dval pulse", dval, 0); chk("R7", "last pulse", last, 0);
    chk("R3", "data hold", data, 32'h2222_2222);
    cyc(1, 0, 0, 32'h5555_5555);
    chk("R10", "dval idle", dval, 0); chk("R10", "pcnt idle", pcnt, 2);
    chk("R10", "wcnt idle", wcnt, 1); chk("R10", "data idle", data, 32'h2222_2222);
    cyc(1, 1, 1, 0);
  endtask

  task automatic t_read_waits();
    is_wr = 1'b0;
    cyc(0, 1, 1, 32'hB000_0000);
    chk("R2", "wr read", wr, 0); chk("R2", "pcnt clr", pcnt, 0); chk("R2", "wcnt clr", wcnt, 0);
    cyc(1, 0, 1, 0);
    chk("R5", "wcnt", wcnt, 1); chk("R8", "no err with irdy", err, 0);
    cyc(1, 0, 0, 32'hCAFE_F00D);
    chk("R7", "single last", last, 1); chk("R3", "data", data, 32'hCAFE_F00D);
    chk("R4", "pcnt", pcnt, 1); chk("R5", "wcnt kept", wcnt, 1);
    cyc(1, 1, 1, 0);
  endtask

  task automatic t_saturate();
    cyc(0, 1, 1, 0);
    for (int k = 0; k < 20; k++) cyc(0, 0, 1, 0);
    chk("R6", "wcnt sat", wcnt, 15);
    cyc(1, 0, 0, 32'h0000_0077);
    chk("R6", "wcnt sat hold", wcnt, 15); chk("R7", "last", last, 1);
    cyc(1, 1, 1, 0);
  endtask

  task automatic t_error();
    cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0);
    cyc(1, 1, 1, 0);
    chk("R8", "err", err, 1); chk("R8", "dval", dval, 0);
    chk("R8", "wcnt not counted", wcnt, 1);
    cyc(1, 0, 0, 32'h9999_9999);
    chk("R8", "err pulse", err, 0); chk("R8", "idle after err", dval, 0);
    chk("R8", "pcnt", pcnt, 0);
  endtask

  task automatic t_back2back();
    cyc(0, 1, 1, 0);
    cyc(1, 0, 0, 32'h0000_0001);
    chk("R9", "first last", last, 1);
    cyc(0, 1, 1, 0);
    chk("R9", "new addr pcnt", pcnt, 0); chk("R9", "dval", dval, 0);
    for (int k = 0; k < 257; k++) cyc(0, 0, 0, 32'(k));
    chk("R4", "wrap", pcnt, 1); chk("R9", "burst no last", last, 0);
    chk("R9", "burst dval", dval, 1); chk("R3", "burst data", data, 256);
    cyc(1, 0, 0, 32'hFFFF_0000);
    chk("R4", "pcnt", pcnt, 2); chk("R7", "last", last, 1);
    cyc(1, 1, 1, 0);
  endtask

  initial begin
    #40;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_write_burst();
    t_read_waits();
    t_saturate();
    t_error();
    t_back2back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule